// File: doc/BRIEF.md
# Signed-Digit Scalar Splitter

This block prepares work for a bank of parallel point-multiplication units. It receives one scalar as a string of signed digits, either a binary or a tau-adic non-adjacent form, of up to `DIGITS` positions, and divides it into sub-scalars, one per active unit. Every nonzero digit of the input ends up in exactly one sub-scalar. The partial results of the units can then be combined into the full product. Point arithmetic, base-point precomputation and the final combination of the partial results are handled outside this block.

Two splitting strategies are offered. The cyclic strategy walks the digits from the least significant end, one digit per clock. It deals each nonzero digit to the next unit in turn, and the digit keeps its original position. The result is the smallest possible largest per-unit nonzero count, and every unit uses the unshifted base point. The window strategy cuts the string into equal windows of `ceil(DIGITS/n)` digits. Each window is shifted down to position zero. Each unit receives an exponent that says by how many doublings or Frobenius steps its base point must be advanced. For every unit the block also reports the nonzero count and the shift exponent, and it reports the largest count across all units.

Top module: `scalar_splitter`

## Requirements
- R1: Each digit uses two bits: 00 means 0, 01 means +1 and 11 means -1. Code 10 is reserved. A reserved digit is treated as zero, and `err_o` is high from `done_o` until the next accepted start.
- R2: Each nonzero input digit appears in exactly one active sub-scalar with its sign unchanged. Every other sub-scalar holds 00 at the position that corresponds to that digit.
- R3: In cyclic mode the digits are scanned from position 0 upward. The k-th nonzero digit (counting from 0) goes to unit k mod n at its original position.
- R4: In cyclic mode every shift exponent is 0, and the largest per-unit count equals ceil(total nonzeros / n). For example, 35 nonzeros over 4 units give 9.
- R5: In window mode, w = ceil(DIGITS/n). Unit i holds input digits i·w up to i·w+w-1 (clipped at the top of the string), placed at positions 0 up to w-1, and its shift exponent is i·w.
- R6: `nz_count_o` gives the number of nonzero digits in each sub-scalar, and `max_count_o` gives the largest of these counts.
- R7: A unit with index n or higher gets an all-zero sub-scalar, a count of 0 and an exponent of 0.
- R8: In cyclic mode `done_o` is high for one cycle, DIGITS cycles after the clock edge that accepts start. In window mode it is high in the cycle right after that edge. All outputs hold their values until the next accepted start.
- R9: A start that arrives while a cyclic scan is still running is ignored. The running split finishes unchanged and produces no extra `done_o`.
- R10: A unit count of 0, or one above UNITS, raises `err_o` and is handled as a single unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new split; sampled when idle |
| mode_win | input | 1 | 0 = cyclic split, 1 = window split |
| num_units | input | $clog2(UNITS+1) | Number of active units n |
| digits_in | input | 2·DIGITS | Signed-digit scalar, digit p at bits 2p+1:2p |
| sub_digits_o | output | UNITS·DIGITS·2 | Sub-scalars, unit u digit p at bits 2(u·DIGITS+p)+1:2(u·DIGITS+p) |
| nz_count_o | output | UNITS·$clog2(DIGITS+1) | Nonzero count per unit |
| shift_exp_o | output | UNITS·$clog2(DIGITS+1) | Base-point shift exponent per unit |
| max_count_o | output | $clog2(DIGITS+1) | Largest per-unit count |
| done_o | output | 1 | Split complete |
| err_o | output | 1 | Reserved digit or invalid unit count seen |

## Verification
The assertions check a set of properties on every cycle:
- In cyclic mode, the completion latency is exact.
- In cyclic mode, the largest count never exceeds the balanced bound, and all exponents are zero.
- Idle units stay empty.
- The maximum covers every count.
- The scan advances one digit per cycle, and the chosen unit stays in range.
- A start that arrives while the block is busy does not change the latched configuration.

Only the bench scenarios can show the exact placement of each digit. These scenarios cover the round-robin order, the window boundaries when DIGITS is not a multiple of n, sign preservation, the handling of reserved codes and bad unit counts, and the holding of outputs after completion.

// File: rtl/scalar_split_pkg.sv
package scalar_split_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_RSV  = 2'b10,
        DIG_NEG  = 2'b11
    } sdigit_e;

    // Reserved code is folded to zero before any placement
    function automatic logic [1:0] clean_digit(input logic [1:0] d);
        return (d == DIG_RSV) ? DIG_ZERO : d;
    endfunction

    function automatic logic digit_nz(input logic [1:0] d);
        return (d == DIG_POS) || (d == DIG_NEG);
    endfunction

    // Window length for a string of total digits over n units
    function automatic int win_width(input int total, input int n);
        return (n <= 0) ? total : (total + n - 1) / n;
    endfunction

endpackage

// File: rtl/split_rr_sched.sv
module split_rr_sched
    import scalar_split_pkg::*;
#(
    parameter int DIGITS = 163,
    parameter int UNITS  = 8,
    localparam int NU_W   = $clog2(UNITS + 1),
    localparam int POS_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int UPTR_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [NU_W-1:0]   n_units,
    input  logic              cur_nz,
    output logic              busy,
    output logic [POS_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [UPTR_W-1:0] wr_unit,
    output logic              finish
);

    logic              active_q;
    logic [POS_W-1:0]  idx_q;
    logic [UPTR_W-1:0] ptr_q;
    logic [NU_W-1:0]   nlim_q;
    logic              last_pos;
    logic              ptr_wrap;

    always_comb begin
        last_pos = (idx_q == POS_W'(DIGITS - 1));
        ptr_wrap = (NU_W'(ptr_q) == nlim_q - NU_W'(1));
        busy     = active_q;
        rd_idx   = idx_q;
        wr_en    = active_q && cur_nz;
        wr_unit  = ptr_q;
        finish   = active_q && last_pos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            ptr_q    <= '0;
            nlim_q   <= NU_W'(1);
        end else if (launch && !active_q) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            ptr_q    <= '0;
            nlim_q   <= n_units;
        end else if (active_q) begin
            if (wr_en)
                ptr_q <= ptr_wrap ? '0 : ptr_q + UPTR_W'(1);
            if (last_pos)
                active_q <= 1'b0;
            else
                idx_q <= idx_q + POS_W'(1);
        end
    end

    AST_UNIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (NU_W'(wr_unit) < nlim_q)) else $error("unit out of range"); // R3

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last_pos) |=> (rd_idx == $past(rd_idx) + POS_W'(1))) else $error("scan skipped"); // R3

endmodule

// File: rtl/split_window_map.sv
module split_window_map
    import scalar_split_pkg::*;
#(
    parameter int DIGITS = 163,
    parameter int UNITS  = 8,
    localparam int NU_W  = $clog2(UNITS + 1),
    localparam int CNT_W = $clog2(DIGITS + 1)
) (
    input  logic [DIGITS-1:0][1:0]             digs,
    input  logic [NU_W-1:0]                    n_units,
    output logic [UNITS-1:0][DIGITS-1:0][1:0]  sub,
    output logic [UNITS-1:0][CNT_W-1:0]        cnt,
    output logic [UNITS-1:0][CNT_W-1:0]        expo
);

    int win_w;
    logic [2*DIGITS-1:0] flat;

    always_comb begin
        win_w = win_width(DIGITS, int'(n_units));
        flat  = digs;
    end

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        int                  base_u;
        logic                live_u;
        logic [2*DIGITS-1:0] shifted_u;

        always_comb begin
            base_u    = u * win_w;
            live_u    = (u < int'(n_units));
            shifted_u = flat >> (2 * base_u);
            cnt[u]    = '0;
            for (int p = 0; p < DIGITS; p++) begin
                if (live_u && (p < win_w)) begin
                    sub[u][p] = shifted_u[2*p +: 2];
                    cnt[u]    = cnt[u] + CNT_W'(digit_nz(shifted_u[2*p +: 2]));
                end else begin
                    sub[u][p] = 2'b00;
                end
            end
            expo[u] = live_u ? CNT_W'(base_u) : '0;
        end
    end

endmodule

// File: rtl/split_max_reduce.sv
module split_max_reduce #(
    parameter int UNITS = 8,
    parameter int CNT_W = 8
) (
    input  logic [UNITS-1:0][CNT_W-1:0] vals,
    output logic [CNT_W-1:0]            max_o
);

    always_comb begin
        max_o = '0;
        for (int u = 0; u < UNITS; u++)
            if (vals[u] > max_o)
                max_o = vals[u];
    end

endmodule

// File: rtl/scalar_splitter.sv
module scalar_splitter
    import scalar_split_pkg::*;
#(
    parameter int DIGITS = 163,
    parameter int UNITS  = 8,
    localparam int CNT_W = $clog2(DIGITS + 1),
    localparam int NU_W  = $clog2(UNITS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         mode_win,
    input  logic [NU_W-1:0]              num_units,
    input  logic [2*DIGITS-1:0]          digits_in,
    output logic [UNITS*DIGITS*2-1:0]    sub_digits_o,
    output logic [UNITS*CNT_W-1:0]       nz_count_o,
    output logic [UNITS*CNT_W-1:0]       shift_exp_o,
    output logic [CNT_W-1:0]             max_count_o,
    output logic                         done_o,
    output logic                         err_o
);

    localparam int POS_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam int UPTR_W = (UNITS > 1) ? $clog2(UNITS) : 1;
    localparam int BAL_W  = CNT_W + NU_W;

    typedef logic [DIGITS-1:0][1:0]            dstr_t;
    typedef logic [UNITS-1:0][DIGITS-1:0][1:0] bank_t;
    typedef logic [UNITS-1:0][CNT_W-1:0]       cvec_t;

    // Input conditioning
    logic            bad_n;
    logic [NU_W-1:0] n_in;
    logic            any_rsv;
    dstr_t           clean_in;

    always_comb begin
        bad_n   = (num_units == '0) || (num_units > NU_W'(UNITS));
        n_in    = bad_n ? NU_W'(1) : num_units;
        any_rsv = 1'b0;
        for (int p = 0; p < DIGITS; p++) begin
            clean_in[p] = clean_digit(digits_in[2*p +: 2]);
            if (digits_in[2*p +: 2] == DIG_RSV)
                any_rsv = 1'b1;
        end
    end

    // State
    bank_t           sub_q;
    cvec_t           cnt_q;
    cvec_t           exp_q;
    dstr_t           src_q;
    logic            done_q;
    logic            err_q;
    logic            mode_q;
    logic [NU_W-1:0] n_q;

    // Cyclic scheduler
    logic              busy;
    logic [POS_W-1:0]  rd_idx;
    logic              wr_en;
    logic [UPTR_W-1:0] wr_unit;
    logic              finish;
    logic              accept;

    assign accept = start && !busy;

    split_rr_sched #(.DIGITS(DIGITS), .UNITS(UNITS)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .launch  (accept && !mode_win),
        .n_units (n_in),
        .cur_nz  (digit_nz(src_q[rd_idx])),
        .busy    (busy),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_unit (wr_unit),
        .finish  (finish)
    );

    // Window mapper
    bank_t win_sub;
    cvec_t win_cnt;
    cvec_t win_exp;

    split_window_map #(.DIGITS(DIGITS), .UNITS(UNITS)) u_win (
        .digs    (clean_in),
        .n_units (n_in),
        .sub     (win_sub),
        .cnt     (win_cnt),
        .expo    (win_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q  <= '0;
            cnt_q  <= '0;
            exp_q  <= '0;
            src_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            mode_q <= 1'b0;
            n_q    <= NU_W'(1);
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= mode_win;
                n_q    <= n_in;
                err_q  <= any_rsv || bad_n;
                if (mode_win) begin
                    sub_q  <= win_sub;
                    cnt_q  <= win_cnt;
                    exp_q  <= win_exp;
                    done_q <= 1'b1;
                end else begin
                    sub_q <= '0;
                    cnt_q <= '0;
                    exp_q <= '0;
                    src_q <= clean_in;
                end
            end else begin
                if (wr_en) begin
                    sub_q[wr_unit][rd_idx] <= src_q[rd_idx];
                    cnt_q[wr_unit]         <= cnt_q[wr_unit] + CNT_W'(1);
                end
                if (finish)
                    done_q <= 1'b1;
            end
        end
    end

    split_max_reduce #(.UNITS(UNITS), .CNT_W(CNT_W)) u_max (
        .vals  (cnt_q),
        .max_o (max_count_o)
    );

    assign sub_digits_o = sub_q;
    assign nz_count_o   = cnt_q;
    assign shift_exp_o  = exp_q;
    assign done_o       = done_q;
    assign err_o        = err_q;

    // Checker support: cycles since accepted start, total count, balance bound
    logic [CNT_W-1:0] lat_q;
    logic [CNT_W-1:0] tot_nz;
    logic [BAL_W-1:0] bal_lhs;
    logic [BAL_W-1:0] bal_rhs;

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else if (accept)
            lat_q <= '0;
        else if (busy)
            lat_q <= lat_q + CNT_W'(1);
    end

    always_comb begin
        tot_nz = '0;
        for (int u = 0; u < UNITS; u++)
            tot_nz = tot_nz + cnt_q[u];
        bal_lhs = BAL_W'(max_count_o) * BAL_W'(n_q);
        bal_rhs = BAL_W'(tot_nz) + BAL_W'(n_q) - BAL_W'(1);
    end

    AST_CYC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_q) |-> (lat_q == CNT_W'(DIGITS))) else $error("cyclic latency"); // R8

    AST_WIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q) |-> $past(start)) else $error("window latency"); // R8

    AST_CYC_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_q) |-> (exp_q == '0)) else $error("cyclic shift nonzero"); // R4

    AST_CYC_BALANCE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_q) |-> (bal_lhs <= bal_rhs)) else $error("cyclic imbalance"); // R4

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (n_q == $past(n_q) && mode_q == $past(mode_q))) else $error("busy start taken"); // R9

    for (genvar u = 0; u < UNITS; u++) begin : g_chk
        AST_IDLE_UNIT: assert property (@(posedge clk) disable iff (rst)
            (done_o && (NU_W'(u) >= n_q)) |-> (cnt_q[u] == '0 && exp_q[u] == '0)) else $error("idle unit used"); // R7

        AST_MAX_COVERS: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (max_count_o >= cnt_q[u])) else $error("max below count"); // R6
    end

endmodule

// File: tb/tb_scalar_splitter.sv
module tb_scalar_splitter;

    localparam int L          = 163;
    localparam int U          = 8;
    localparam int CW         = $clog2(L + 1);
    localparam int NW         = $clog2(U + 1);
    localparam int CLK_PERIOD = 10;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic                mode_win = 1'b0;
    logic [NW-1:0]       num_units = NW'(1);
    logic [2*L-1:0]      digits_in = '0;
    logic [U*L*2-1:0]    sub_digits_o;
    logic [U*CW-1:0]     nz_count_o;
    logic [U*CW-1:0]     shift_exp_o;
    logic [CW-1:0]       max_count_o;
    logic                done_o;
    logic                err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    scalar_splitter #(.DIGITS(L), .UNITS(U)) dut (
        .clk(clk), .rst(rst), .start(start), .mode_win(mode_win),
        .num_units(num_units), .digits_in(digits_in),
        .sub_digits_o(sub_digits_o), .nz_count_o(nz_count_o),
        .shift_exp_o(shift_exp_o), .max_count_o(max_count_o),
        .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        logic [U*L*2-1:0] sub;
        logic [U*CW-1:0]  cnt;
        logic [U*CW-1:0]  ex;
        logic [CW-1:0]    mx;
        logic             err;
        int               done_cyc;
        int               nsel;
        int               w;
        bit               cyc;
        logic [2*L-1:0]   src;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_item;
    int   checks = 0;
    int   errors = 0;
    int   cyc_cnt = 0;
    int   done_seen = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc_cnt++;

    function automatic logic [1:0] bclean(input logic [1:0] d);
        return (d == 2'b10) ? 2'b00 : d;
    endfunction

    function automatic exp_t build_exp(input logic [2*L-1:0] d, input bit cyc, input int n);
        exp_t e;
        int   ne, k, w, mx;
        int   c [U];
        bit   bad;
        bit   rsv;
        bad = (n == 0) || (n > U);
        ne  = bad ? 1 : n;
        rsv = 1'b0;
        for (int p = 0; p < L; p++) if (d[2*p +: 2] == 2'b10) rsv = 1'b1;
        e.sub = '0; e.cnt = '0; e.ex = '0;
        for (int u = 0; u < U; u++) c[u] = 0;
        w = (L + ne - 1) / ne;
        if (cyc) begin
            k = 0;
            for (int p = 0; p < L; p++) begin
                logic [1:0] v;
                v = bclean(d[2*p +: 2]);
                if (v != 2'b00) begin
                    e.sub[((k % ne) * L + p) * 2 +: 2] = v;
                    c[k % ne]++;
                    k++;
                end
            end
        end else begin
            for (int u = 0; u < ne; u++) begin
                e.ex[u*CW +: CW] = CW'(u * w);
                for (int p = 0; p < w; p++) begin
                    if (u * w + p < L) begin
                        logic [1:0] v;
                        v = bclean(d[2*(u*w+p) +: 2]);
                        e.sub[(u * L + p) * 2 +: 2] = v;
                        if (v != 2'b00) c[u]++;
                    end
                end
            end
        end
        mx = 0;
        for (int u = 0; u < U; u++) begin
            e.cnt[u*CW +: CW] = CW'(c[u]);
            if (c[u] > mx) mx = c[u];
        end
        e.mx   = CW'(mx);
        e.err  = bad || rsv;
        e.nsel = ne;
        e.w    = w;
        e.cyc  = cyc;
        e.src  = d;
        return e;
    endfunction

    task automatic fail_line(input string req, input string what, input longint act, input longint expv);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    endtask

    task automatic compare_out(input exp_t e);
        for (int u = 0; u < U; u++) begin
            string tg;
            tg = (u >= e.nsel) ? "R7" : (e.cyc ? "R3" : "R5");
            checks++;
            if (sub_digits_o[u*L*2 +: L*2] !== e.sub[u*L*2 +: L*2]) begin
                int bad_p;
                bad_p = 0;
                for (int p = L - 1; p >= 0; p--)
                    if (sub_digits_o[(u*L+p)*2 +: 2] !== e.sub[(u*L+p)*2 +: 2]) bad_p = p;
                fail_line(tg, $sformatf("unit %0d digit %0d", u, bad_p),
                          sub_digits_o[(u*L+bad_p)*2 +: 2], e.sub[(u*L+bad_p)*2 +: 2]);
            end
            checks++;
            if (nz_count_o[u*CW +: CW] !== e.cnt[u*CW +: CW])
                fail_line((u >= e.nsel) ? "R7" : "R6", $sformatf("count unit %0d", u),
                          nz_count_o[u*CW +: CW], e.cnt[u*CW +: CW]);
            checks++;
            if (shift_exp_o[u*CW +: CW] !== e.ex[u*CW +: CW])
                fail_line((u >= e.nsel) ? "R7" : (e.cyc ? "R4" : "R5"), $sformatf("exponent unit %0d", u),
                          shift_exp_o[u*CW +: CW], e.ex[u*CW +: CW]);
        end
        checks++;
        if (max_count_o !== e.mx) fail_line("R6", "max count", max_count_o, e.mx);
        checks++;
        if (err_o !== e.err) fail_line("R1 R10", "error flag", err_o, e.err);
    endtask

    // R2: rebuild the scalar from the outputs; each nonzero digit exactly once
    task automatic check_partition(input exp_t e);
        int  hits [L];
        bit  ok;
        int  badpos;
        ok = 1'b1;
        badpos = 0;
        for (int p = 0; p < L; p++) hits[p] = 0;
        for (int u = 0; u < U; u++) begin
            for (int p = 0; p < L; p++) begin
                logic [1:0] v;
                int orig;
                v = sub_digits_o[(u*L+p)*2 +: 2];
                orig = e.cyc ? p : u * e.w + p;
                if (v != 2'b00) begin
                    if (u >= e.nsel || orig >= L) begin ok = 1'b0; badpos = p; end
                    else begin
                        hits[orig]++;
                        if (v !== bclean(e.src[2*orig +: 2])) begin ok = 1'b0; badpos = orig; end
                    end
                end
            end
        end
        for (int p = 0; p < L; p++) begin
            if (bclean(e.src[2*p +: 2]) != 2'b00 && hits[p] != 1) begin ok = 1'b0; badpos = p; end
            if (bclean(e.src[2*p +: 2]) == 2'b00 && hits[p] != 0) begin ok = 1'b0; badpos = p; end
        end
        checks++;
        if (!ok) fail_line("R2", "partition position", badpos, -1);
    endtask

    // Monitor: pops the scoreboard on each completion
    always @(negedge clk) begin
        if (!rst && done_o && !finished) begin
            if (sb_q.size() == 0) begin
                checks++;
                fail_line("R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (cyc_cnt != e.done_cyc) fail_line("R8", "done cycle", cyc_cnt, e.done_cyc);
                compare_out(e);
                check_partition(e);
                last_item = e;
            end
            done_seen++;
        end
    end

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (done_seen < target && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (done_seen < target) begin
            checks++;
            fail_line("R8", "done timeout", done_seen, target);
        end
    endtask

    task automatic drive(input logic [2*L-1:0] d, input bit cyc, input int n, input bit expect_it);
        exp_t e;
        @(negedge clk);
        digits_in = d;
        mode_win  = !cyc;
        num_units = NW'(n);
        start     = 1'b1;
        if (expect_it) begin
            e = build_exp(d, cyc, n);
            e.done_cyc = cyc_cnt + 1 + (cyc ? L : 0);
            sb_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [2*L-1:0] d, input bit cyc, input int n);
        int target;
        target = done_seen + 1;
        drive(d, cyc, n, 1'b1);
        wait_done(target);
        // R8: outputs hold after the pulse
        repeat (3) @(negedge clk);
        digits_in = ~digits_in;
        @(negedge clk);
        checks++;
        if (done_o !== 1'b0) fail_line("R8", "done not a pulse", done_o, 0);
        compare_out(last_item);
    endtask

    function automatic logic [2*L-1:0] rand_digits(input bit allow_rsv);
        logic [2*L-1:0] d;
        for (int p = 0; p < L; p++) begin
            int r;
            r = $urandom % 5;
            case (r)
                0: d[2*p +: 2] = 2'b01;
                1: d[2*p +: 2] = 2'b11;
                2: d[2*p +: 2] = allow_rsv ? 2'b10 : 2'b00;
                default: d[2*p +: 2] = 2'b00;
            endcase
        end
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2*L-1:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state (R8 outputs idle)
        checks++;
        if (done_o !== 1'b0 || err_o !== 1'b0 || max_count_o !== '0 ||
            sub_digits_o !== '0 || nz_count_o !== '0 || shift_exp_o !== '0)
            fail_line("R8", "reset state", done_o, 0);

        // R4: 35 nonzeros over 4 units, alternating signs
        d = '0;
        for (int k = 0; k < 35; k++) d[2*(4*k) +: 2] = (k % 2) ? 2'b11 : 2'b01;
        run(d, 1'b1, 4);
        checks++;
        if (max_count_o !== CW'(9)) fail_line("R4", "balanced max for 35/4", max_count_o, 9);

        // R3: random signed digits, 8 units, then a single unit
        run(rand_digits(1'b0), 1'b1, 8);
        run(rand_digits(1'b0), 1'b1, 1);
        run(rand_digits(1'b0), 1'b1, 3);

        // R5: window splits with uneven last window
        run(rand_digits(1'b0), 1'b0, 4);
        run(rand_digits(1'b0), 1'b0, 3);
        run(rand_digits(1'b0), 1'b0, 8);
        run(rand_digits(1'b0), 1'b0, 1);

        // All-zero scalar
        run('0, 1'b1, 5);

        // R1: reserved codes in both modes
        run(rand_digits(1'b1), 1'b1, 6);
        run(rand_digits(1'b1), 1'b0, 6);

        // R10: invalid unit counts
        run(rand_digits(1'b0), 1'b0, 0);
        run(rand_digits(1'b0), 1'b1, 12);

        // R9: start while a cyclic scan is running
        begin
            int target;
            target = done_seen + 1;
            drive(rand_digits(1'b0), 1'b1, 5, 1'b1);
            repeat (5) @(negedge clk);
            drive(rand_digits(1'b0), 1'b0, 2, 1'b0);
            wait_done(target);
            repeat (10) @(negedge clk);
            checks++;
            if (done_seen != target) fail_line("R9", "done count after busy start", done_seen, target);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule